// File: doc/BRIEF.md
# Run-Time Depth-Switchable Datapath Pipeline

This block is a fixed-function datapath pipeline whose depth can be changed while the chip is running. It is built from pairs of stages. Each pair has a first register that can be skipped and a second register that is always used. When the skip is off, every stage has its own register, which suits a fast clock. When it is on, the logic of the two stages in each pair runs back to back within one cycle, so the pipeline has half as many registers and half the latency. That suits a slow clock.

Logic outside the block chooses the mode from the current operating speed, using the `halfReq` input. A mode change never corrupts data in flight. While the requested mode differs from the active one, the block raises `drainBusy`, rejects new items and waits for every valid to leave. It switches mode on the next edge after it is empty. There is no backpressure: when no drain is in progress, a new item may enter on every cycle.

Top module: `cbp_pipe`

## Requirements
- R1: A synchronous reset (`rst` high) clears every valid bit and selects full-depth mode. After reset `outValid` is 0, `latency` reads 10 and `drainBusy` is 0 while `halfReq` is 0.
- R2: The 10 stages are indexed i = 0..9. Stage i computes y = rotate-left-by-one(x) + (i+1)*32'h9E3779B9, modulo 2^32. In full-depth mode (`halfReq` = 0) an item accepted in cycle c appears on `outData` with `outValid` = 1 in cycle c+10, and its value is stage 9 applied after stage 8, and so on back to stage 0, applied to the input.
- R3: In half-depth mode (`halfReq` = 1, active) the same composed function is produced, and an item accepted in cycle c appears in cycle c+5. The skippable registers, at stage indices 0, 2, 4, 6 and 8, hold no valid item.
- R4: The valid bit travels with its data. Items that enter on consecutive cycles leave on consecutive cycles, in order, and no output valid appears without a matching accepted input.
- R5: `drainBusy` is high in exactly those cycles where `halfReq` differs from the active mode. An input presented in such a cycle is discarded and never reaches the output.
- R6: The active mode changes only on an edge at which the pipeline holds no valid item. Items already in flight leave with the latency of the mode in which they entered. Returning `halfReq` to the active mode before the pipeline is empty cancels the pending change.
- R7: `latency` reports the latency of the active mode: 10 in full-depth mode and 5 in half-depth mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| halfReq | input | 1 | Requested mode: 1 = half depth (skippable registers bypassed), 0 = full depth |
| inValid | input | 1 | Input item valid |
| inData | input | 32 | Input item data |
| outValid | output | 1 | Output item valid |
| outData | output | 32 | Output item data |
| drainBusy | output | 1 | A mode change is pending; inputs are being rejected |
| latency | output | 4 | Latency of the active mode in cycles (10 or 5) |

## Verification
The bench targets mode changes requested while items are still in flight. A design that switched at once would give those items the new latency, or would lose or duplicate them when the skippable registers are bypassed. The bench also presents items during a drain and then cancels the request before the pipeline empties. An ungated input would then leak out, and a sticky drain flag would leave `drainBusy` high or switch the mode anyway. Back-to-back bursts with edge data values (all zeros, all ones) in both modes show whether the valid bit and the data drift apart, or whether a bypassed pair drops or reorders one of the two chained stage functions.

// File: rtl/cbp_pkg.sv
package cbp_pkg;

  // Strobes passed from the mode controller to the datapath
  typedef struct packed {
    logic bypassEn;  // skip the first register of every stage pair
    logic acceptEn;  // admit new items at the pipeline head
  } cbpCtrl_t;

endpackage

// File: rtl/cbp_stage.sv
// One pipeline stage: a fixed transform followed by a register that can
// optionally be skipped so that the transform feeds the next stage directly.
module cbp_stage #(
  parameter int                 DATA_W     = 32,
  parameter int                 STAGE_IDX  = 0,
  parameter logic [DATA_W-1:0]  STEP_K     = 32'h9E3779B9,
  parameter bit                 CAN_BYPASS = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bypassEn,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              regValid
);

  localparam logic [DATA_W-1:0] ADD_K = DATA_W'(STEP_K * (STAGE_IDX + 1));

  logic [DATA_W-1:0] fnOut;
  logic              skipReg;
  logic              vReg;
  logic [DATA_W-1:0] dReg;

  assign fnOut   = {inData[DATA_W-2:0], inData[DATA_W-1]} + ADD_K;
  assign skipReg = CAN_BYPASS & bypassEn;

  always_ff @(posedge clk) begin
    if (rst) begin
      vReg <= 1'b0;
      dReg <= '0;
    end else begin
      // a skipped register is kept empty
      vReg <= inValid & ~skipReg;
      if (inValid && !skipReg) dReg <= fnOut;
    end
  end

  assign outValid = skipReg ? inValid : vReg;
  assign outData  = skipReg ? fnOut   : dReg;
  assign regValid = vReg;

endmodule

// File: rtl/cbp_datapath.sv
// Chain of stage pairs; the first stage of each pair has a skippable register.
module cbp_datapath
  import cbp_pkg::*;
#(
  parameter int                DATA_W = 32,
  parameter int                PAIRS  = 5,
  parameter logic [DATA_W-1:0] STEP_K = 32'h9E3779B9,
  localparam int               STAGES = 2 * PAIRS
) (
  input  logic              clk,
  input  logic              rst,
  input  cbpCtrl_t          ctrl,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic [STAGES-1:0] validVec,
  output logic              anyValid
);

  logic              chainV [STAGES+1];
  logic [DATA_W-1:0] chainD [STAGES+1];

  assign chainV[0] = inValid & ctrl.acceptEn;
  assign chainD[0] = inData;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    cbp_stage #(
      .DATA_W    (DATA_W),
      .STAGE_IDX (s),
      .STEP_K    (STEP_K),
      .CAN_BYPASS((s % 2) == 0)
    ) u_stage (
      .clk     (clk),
      .rst     (rst),
      .bypassEn(ctrl.bypassEn),
      .inValid (chainV[s]),
      .inData  (chainD[s]),
      .outValid(chainV[s+1]),
      .outData (chainD[s+1]),
      .regValid(validVec[s])
    );
  end

  assign outValid = chainV[STAGES];
  assign outData  = chainD[STAGES];
  assign anyValid = |validVec;

endmodule

// File: rtl/cbp_control.sv
// Mode controller: holds the active mode and drains before a change.
module cbp_control
  import cbp_pkg::*;
#(
  parameter int LAT_W    = 4,
  parameter int FULL_LAT = 10,
  parameter int HALF_LAT = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             halfReq,
  input  logic             anyValid,
  output cbpCtrl_t         ctrl,
  output logic             drainBusy,
  output logic [LAT_W-1:0] latency
);

  logic curHalf;

  always_ff @(posedge clk) begin
    if (rst) begin
      curHalf <= 1'b0;
    end else if (halfReq != curHalf && !anyValid) begin
      curHalf <= halfReq;
    end
  end

  always_comb begin
    drainBusy     = (halfReq != curHalf);
    ctrl.acceptEn = ~drainBusy;
    ctrl.bypassEn = curHalf;
    latency       = curHalf ? LAT_W'(HALF_LAT) : LAT_W'(FULL_LAT);
  end

endmodule

// File: rtl/cbp_pipe.sv
// Top: depth-switchable pipeline.
module cbp_pipe
  import cbp_pkg::*;
#(
  parameter int                DATA_W = 32,
  parameter int                PAIRS  = 5,
  parameter logic [DATA_W-1:0] STEP_K = 32'h9E3779B9,
  localparam int               STAGES   = 2 * PAIRS,
  localparam int               FULL_LAT = STAGES,
  localparam int               HALF_LAT = PAIRS,
  localparam int               LAT_W    = $clog2(FULL_LAT + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              halfReq,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              drainBusy,
  output logic [LAT_W-1:0]  latency
);

  cbpCtrl_t          ctrlBus;
  logic [STAGES-1:0] validVec;
  logic              anyValid;

  cbp_control #(
    .LAT_W   (LAT_W),
    .FULL_LAT(FULL_LAT),
    .HALF_LAT(HALF_LAT)
  ) u_control (
    .clk      (clk),
    .rst      (rst),
    .halfReq  (halfReq),
    .anyValid (anyValid),
    .ctrl     (ctrlBus),
    .drainBusy(drainBusy),
    .latency  (latency)
  );

  cbp_datapath #(
    .DATA_W(DATA_W),
    .PAIRS (PAIRS),
    .STEP_K(STEP_K)
  ) u_datapath (
    .clk     (clk),
    .rst     (rst),
    .ctrl    (ctrlBus),
    .inValid (inValid),
    .inData  (inData),
    .outValid(outValid),
    .outData (outData),
    .validVec(validVec),
    .anyValid(anyValid)
  );

endmodule

// File: rtl/cbp_pipe_chk.sv
// Assertion checker attached to cbp_pipe.
module cbp_pipe_chk #(
  parameter int STAGES   = 10,
  parameter int LAT_W    = 4,
  parameter int FULL_LAT = 10,
  parameter int HALF_LAT = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              drainBusy,
  input logic [LAT_W-1:0]  latency,
  input logic              outValid,
  input logic [STAGES-1:0] validVec,
  input logic              anyValid
);

  function automatic logic [STAGES-1:0] skipMask();
    logic [STAGES-1:0] m = '0;
    for (int s = 0; s < STAGES; s += 2) m[s] = 1'b1;
    return m;
  endfunction

  localparam logic [STAGES-1:0] SKIP_MASK = skipMask();

  // R6: the active mode moves only after an empty cycle
  p_switch_when_empty_r6: assert property (@(posedge clk) disable iff (rst)
    (latency != $past(latency)) |-> !$past(anyValid));

  // R5: while draining, nothing enters the first stage
  p_drain_blocks_r5: assert property (@(posedge clk) disable iff (rst)
    drainBusy |=> !validVec[0]);

  // R7: only the two legal latency values are reported
  p_latency_legal_r7: assert property (@(posedge clk) disable iff (rst)
    (latency == LAT_W'(FULL_LAT)) || (latency == LAT_W'(HALF_LAT)));

  // R3: skipped registers stay empty in half-depth mode
  p_skip_empty_r3: assert property (@(posedge clk) disable iff (rst)
    (latency == LAT_W'(HALF_LAT)) |-> ((validVec & SKIP_MASK) == '0));

  // R4: in full-depth mode the output valid comes from the stage before
  p_full_flow_r4: assert property (@(posedge clk) disable iff (rst)
    (latency == LAT_W'(FULL_LAT) && $past(latency) == LAT_W'(FULL_LAT))
      |-> (outValid == $past(validVec[STAGES-2])));

endmodule

bind cbp_pipe cbp_pipe_chk #(
  .STAGES  (STAGES),
  .LAT_W   (LAT_W),
  .FULL_LAT(FULL_LAT),
  .HALF_LAT(HALF_LAT)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .drainBusy(drainBusy),
  .latency  (latency),
  .outValid (outValid),
  .validVec (validVec),
  .anyValid (anyValid)
);

// File: tb/cbp_pipe_bench.sv
module cbp_pipe_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic        halfReq;
  logic        inValid;
  logic [31:0] inData;
  logic        outValid;
  logic [31:0] outData;
  logic        drainBusy;
  logic [3:0]  latency;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  int lastDue = -1;
  bit expHalf = 1'b0;
  bit done = 1'b0;
  logic [31:0] qData[$];
  int          qDue[$];

  always #4 clk = ~clk;  // 125 MHz

  cbp_pipe u_cbp_pipe (
    .clk(clk), .rst(rst), .halfReq(halfReq), .inValid(inValid),
    .inData(inData), .outValid(outValid), .outData(outData),
    .drainBusy(drainBusy), .latency(latency)
  );

  function automatic logic [31:0] refFn(logic [31:0] x);
    logic [31:0] y = x;
    for (int i = 0; i < 10; i++) y = {y[30:0], y[31]} + 32'(32'h9E3779B9 * (i + 1));
    return y;
  endfunction

  function automatic int latOf(bit h);
    return h ? 5 : 10;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s cycle %0d: actual %h expected %h", req, cyc, act, exp);
    end
  endtask

  task automatic step(bit v, logic [31:0] d, bit h);
    bit busyExp;
    bit inFlight;
    halfReq = h; inValid = v; inData = d;
    #1;
    busyExp = (h != expHalf);
    check(drainBusy == busyExp, "R5 drainBusy", 32'(drainBusy), 32'(busyExp));
    inFlight = (lastDue >= cyc);
    if (v && !busyExp) begin
      qData.push_back(refFn(d));
      qDue.push_back(cyc + latOf(expHalf));
      lastDue = cyc + latOf(expHalf);
    end
    if (busyExp && !inFlight) expHalf = h;  // R6 switch on the coming edge
    @(posedge clk);
    @(negedge clk);
    cyc++;
    if (qDue.size() > 0 && qDue[0] == cyc) begin
      check(outValid == 1'b1, expHalf ? "R3 R4 valid" : "R2 R4 valid", 32'(outValid), 32'd1);
      check(outData == qData[0], "R2 R3 data", outData, qData[0]);
      void'(qData.pop_front());
      void'(qDue.pop_front());
    end else begin
      check(outValid == 1'b0, "R4 R5 R6 spurious valid", 32'(outValid), 32'd0);
    end
    check(latency == 4'(latOf(expHalf)), "R7 latency", 32'(latency), 32'(latOf(expHalf)));
  endtask

  initial begin
    bit reqH;
    void'($urandom(32'd1234));
    rst = 1'b1; halfReq = 1'b0; inValid = 1'b0; inData = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 reset state
    check(outValid == 1'b0, "R1 outValid", 32'(outValid), 32'd0);
    check(latency == 4'd10, "R1 latency", 32'(latency), 32'd10);
    check(drainBusy == 1'b0, "R1 drainBusy", 32'(drainBusy), 32'd0);

    // R2: single item then a back-to-back burst in full depth
    step(1'b1, 32'h0, 1'b0);
    repeat (12) step(1'b0, 32'h0, 1'b0);
    step(1'b1, 32'hFFFF_FFFF, 1'b0);
    for (int i = 0; i < 20; i++) step(1'b1, 32'(i * 32'h0101_0101), 1'b0);
    // R6: request half depth with a full pipeline, keep offering items (R5)
    for (int i = 0; i < 16; i++) step(1'b1, 32'hA5A5_0000 + 32'(i), 1'b1);
    // R3: burst in half depth
    step(1'b1, 32'hFFFF_FFFF, 1'b1);
    for (int i = 0; i < 20; i++) step(1'b1, $urandom, 1'b1);
    // R6: ask for full depth and cancel before the pipeline empties
    step(1'b1, 32'h1111_1111, 1'b0);
    step(1'b1, 32'h2222_2222, 1'b0);
    for (int i = 0; i < 6; i++) step(1'b1, $urandom, 1'b1);
    // R6: switch back to full depth while items are in flight
    for (int i = 0; i < 10; i++) step(1'b1, $urandom, 1'b0);

    // constrained random mix
    reqH = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      if (($urandom % 120) == 0) reqH = ~reqH;
      step(($urandom % 10) < 7, $urandom, reqH);
    end
    repeat (15) step(1'b0, 32'h0, reqH);
    check(qDue.size() == 0, "R4 items left", 32'(qDue.size()), 32'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule